// File: doc/BRIEF.md
# Decimal Floating-Point Restoring Divider

The block divides one 32-bit decimal floating-point number by another. Each operand holds a sign bit in bit 31, a 7-bit exponent code in bits 30:24 and six BCD mantissa digits in bits 23:0. The mantissa reads as d.ddddd, and its leading digit is non-zero. The exponent code is two BCD digits: a tens digit in bits 30:28 and a units digit in bits 27:24. A code c from 00 to 39 stands for the exponent c. A code from 40 to 79 stands for c - 80, so -1 is written 79.

A one-cycle `start` pulse loads both operands. The mantissas are placed in 48-bit working registers. For each quotient digit, the block subtracts the divisor from the remainder once per cycle for as long as the result stays non-negative, and counts the subtractions. The first subtraction that goes negative is undone by a single add-back. The count then enters the quotient from the low end, and the divisor moves one digit to the right. When the dividend mantissa is smaller than the divisor mantissa, the first digit is zero. One more digit is then produced and the exponent is lowered by one. The result is truncated, never rounded, and appears with a one-cycle `done` pulse.

Top module: `bcdfp_div`

## Requirements
- R1: After reset, `quotient` is 0, and both `done` and `div_zero` are 0.
- R2: For non-zero divisors with dividend mantissa Ma >= divisor mantissa Mb (read as integers), the result mantissa is floor(Ma*10^5/Mb) in six BCD digits, truncated.
- R3: The result sign (bit 31) is the XOR of the two operand signs.
- R4: The result exponent code encodes (ea - eb) wrapped modulo 80, where a code c means c for c < 40 and c - 80 otherwise. Tens digit in bits 30:28, units in bits 27:24.
- R5: When Ma < Mb, the mantissa is floor(Ma*10^6/Mb), the exponent is ea - eb - 1 (wrapped modulo 80), and every result has a non-zero leading digit.
- R6: A divisor mantissa of zero gives `done` and `div_zero` high in the cycle right after `start` is sampled, with `quotient` equal to 0.
- R7: `done` is high for exactly one cycle per accepted operation, and `div_zero` is low on every result with a non-zero divisor.
- R8: A `start` pulse that arrives while a division is in progress is ignored: it produces no extra `done` and leaves the result unchanged.
- R9: `quotient` and `div_zero` hold their values between `done` pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load operands and begin; sampled when idle |
| dividend | input | 32 | Numerator: sign, exponent code, 6 BCD digits |
| divisor | input | 32 | Denominator, same format |
| quotient | output | 32 | Registered result, same format |
| done | output | 1 | One-cycle result strobe |
| div_zero | output | 1 | Divisor mantissa was zero |

## Verification
The assertions take both operands to be normalized: every mantissa nibble is a decimal digit, and the leading digit is non-zero unless the divisor is entirely zero. Under that assumption no digit count can exceed nine, and an add-back always returns a carry. The stimulus builds every operand from decimal digits with a non-zero leading digit. A zero mantissa appears only as the divisor in the divide-by-zero case, and exponent codes stay within 00..79.

// File: rtl/bcdfp_pkg.sv
package bcdfp_pkg;
  localparam int EXP_W   = 7;
  localparam int EXP_MOD = 80;

  // two-digit exponent code (3-bit tens, 4-bit units) to binary 0..79
  function automatic logic [6:0] code_to_bin(input logic [6:0] c);
    return ({4'b0, c[6:4]} * 7'd10) + {3'b0, c[3:0]};
  endfunction

  // binary 0..79 back to two-digit code
  function automatic logic [6:0] bin_to_code(input logic [6:0] v);
    logic [6:0] tens;
    logic [6:0] units;
    tens  = v / 7'd10;
    units = v - tens * 7'd10;
    return {tens[2:0], units[3:0]};
  endfunction
endpackage

// File: rtl/bcd_addsub.sv
module bcd_addsub #(
  parameter int DIGITS   = 12,
  parameter bit SUBTRACT = 1'b0
) (
  input  logic [4*DIGITS-1:0] a,
  input  logic [4*DIGITS-1:0] b,
  output logic [4*DIGITS-1:0] y,
  output logic                cout
);
  logic [4*DIGITS-1:0] b_eff;

  // nine's complement of the second operand in the subtract variant
  for (genvar g = 0; g < DIGITS; g++) begin : g_operand
    if (SUBTRACT) begin : g_nines
      assign b_eff[4*g +: 4] = 4'd9 - b[4*g +: 4];
    end else begin : g_plain
      assign b_eff[4*g +: 4] = b[4*g +: 4];
    end
  end

  always_comb begin
    logic       carry;
    logic [4:0] s;
    carry = SUBTRACT;
    y     = '0;
    for (int i = 0; i < DIGITS; i++) begin
      s = {1'b0, a[4*i +: 4]} + {1'b0, b_eff[4*i +: 4]} + {4'b0, carry};
      if (s > 5'd9) begin
        y[4*i +: 4] = 4'(s + 5'd6);
        carry       = 1'b1;
      end else begin
        y[4*i +: 4] = s[3:0];
        carry       = 1'b0;
      end
    end
    cout = carry;
  end
endmodule

// File: rtl/bcdfp_exp_unit.sv
module bcdfp_exp_unit
  import bcdfp_pkg::*;
(
  input  logic [EXP_W-1:0] code_a,
  input  logic [EXP_W-1:0] code_b,
  input  logic             dec,
  output logic [EXP_W-1:0] code_q
);
  logic [7:0] diff;
  logic [6:0] wrapped;
  logic [6:0] adjusted;

  always_comb begin
    diff = {1'b0, code_to_bin(code_a)} + 8'(EXP_MOD) - {1'b0, code_to_bin(code_b)};
    if (diff >= 8'(EXP_MOD)) wrapped = 7'(diff - 8'(EXP_MOD));
    else                     wrapped = diff[6:0];
    if (!dec)                adjusted = wrapped;
    else if (wrapped == 7'd0) adjusted = 7'(EXP_MOD - 1);
    else                     adjusted = wrapped - 7'd1;
    code_q = bin_to_code(adjusted);
  end
endmodule

// File: rtl/bcdfp_div_core.sv
module bcdfp_div_core
  import bcdfp_pkg::*;
#(
  parameter int MANT_DIGITS = 6
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          start,
  input  logic [EXP_W+4*MANT_DIGITS:0]  op_a,
  input  logic [EXP_W+4*MANT_DIGITS:0]  op_b,
  output logic [EXP_W+4*MANT_DIGITS:0]  q_out,
  output logic                          done_out,
  output logic                          dz_out
);
  localparam int MW  = 4 * MANT_DIGITS;
  localparam int WD  = 2 * MANT_DIGITS;
  localparam int WW  = 4 * WD;
  localparam int QD  = MANT_DIGITS + 1;
  localparam int OPW = 1 + EXP_W + MW;
  localparam int DCW = $clog2(QD + 1);

  typedef enum logic [1:0] {S_IDLE, S_SUB, S_RESTORE, S_FINISH} state_t;

  state_t           state_q;
  logic [WW-1:0]    rem_q, dvs_q;
  logic [MW-1:0]    quo_q;
  logic [3:0]       cnt_q;
  logic [DCW-1:0]   ndig_q;
  logic             lead0_q, sign_q;
  logic [EXP_W-1:0] exp_a_q, exp_b_q, exp_res;

  logic [WW-1:0]    diff, sum;
  logic             sub_carry, add_carry;
  logic             lead_now, last_digit;
  logic [MW-1:0]    mant_a, mant_b;

  assign mant_a = op_a[MW-1:0];
  assign mant_b = op_b[MW-1:0];

  bcd_addsub #(.DIGITS(WD), .SUBTRACT(1'b1)) u_sub (
    .a(rem_q), .b(dvs_q), .y(diff), .cout(sub_carry)
  );

  bcd_addsub #(.DIGITS(WD), .SUBTRACT(1'b0)) u_add (
    .a(rem_q), .b(dvs_q), .y(sum), .cout(add_carry)
  );

  bcdfp_exp_unit u_exp (
    .code_a(exp_a_q), .code_b(exp_b_q), .dec(lead0_q), .code_q(exp_res)
  );

  always_comb begin
    lead_now   = (ndig_q == '0) ? (cnt_q == 4'd0) : lead0_q;
    last_digit = ({1'b0, ndig_q} + 1'b1) == (DCW+1)'(lead_now ? QD : MANT_DIGITS);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q  <= S_IDLE;
      rem_q    <= '0;
      dvs_q    <= '0;
      quo_q    <= '0;
      cnt_q    <= '0;
      ndig_q   <= '0;
      lead0_q  <= 1'b0;
      sign_q   <= 1'b0;
      exp_a_q  <= '0;
      exp_b_q  <= '0;
      q_out    <= '0;
      done_out <= 1'b0;
      dz_out   <= 1'b0;
    end else begin
      done_out <= 1'b0;
      case (state_q)
        S_IDLE: begin
          if (start) begin
            if (mant_b == '0) begin
              q_out    <= '0;
              done_out <= 1'b1;
              dz_out   <= 1'b1;
            end else begin
              sign_q  <= op_a[OPW-1] ^ op_b[OPW-1];
              exp_a_q <= op_a[OPW-2 -: EXP_W];
              exp_b_q <= op_b[OPW-2 -: EXP_W];
              rem_q   <= {mant_a, {MW{1'b0}}};
              dvs_q   <= {mant_b, {MW{1'b0}}};
              quo_q   <= '0;
              cnt_q   <= '0;
              ndig_q  <= '0;
              lead0_q <= 1'b0;
              state_q <= S_SUB;
            end
          end
        end
        S_SUB: begin
          rem_q <= diff;
          if (sub_carry) cnt_q <= cnt_q + 4'd1;
          else           state_q <= S_RESTORE;
        end
        S_RESTORE: begin
          rem_q   <= sum;
          quo_q   <= {quo_q[MW-5:0], cnt_q};
          dvs_q   <= {4'b0, dvs_q[WW-1:4]};
          cnt_q   <= '0;
          ndig_q  <= ndig_q + 1'b1;
          lead0_q <= lead_now;
          state_q <= last_digit ? S_FINISH : S_SUB;
        end
        default: begin
          q_out    <= {sign_q, exp_res, quo_q};
          done_out <= 1'b1;
          dz_out   <= 1'b0;
          state_q  <= S_IDLE;
        end
      endcase
    end
  end

  // R2: with normalized operands a tenth subtraction must always borrow
  p_cnt_cap_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_SUB && cnt_q == 4'd9) |-> !sub_carry);

  // R2: the add-back takes a negative (tens-complement) remainder to a non-negative one
  p_restore_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_RESTORE) |-> add_carry);

  // R8: captured operand attributes do not move while a division runs
  p_busy_ignore_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q != S_IDLE) |=> ($stable(sign_q) && $stable(exp_a_q) && $stable(exp_b_q)));

  // R5: the digit loop always ends on a non-zero leading digit
  p_lead_digit_r5: assert property (@(posedge clk) disable iff (rst)
    (state_q == S_FINISH) |-> (quo_q[MW-1 -: 4] != 4'd0));
endmodule

// File: rtl/bcdfp_div.sv
module bcdfp_div
  import bcdfp_pkg::*;
#(
  parameter int MANT_DIGITS = 6
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         start,
  input  logic [EXP_W+4*MANT_DIGITS:0] dividend,
  input  logic [EXP_W+4*MANT_DIGITS:0] divisor,
  output logic [EXP_W+4*MANT_DIGITS:0] quotient,
  output logic                         done,
  output logic                         div_zero
);
  localparam int MW = 4 * MANT_DIGITS;

  bcdfp_div_core #(.MANT_DIGITS(MANT_DIGITS)) u_core (
    .clk(clk), .rst(rst), .start(start),
    .op_a(dividend), .op_b(divisor),
    .q_out(quotient), .done_out(done), .dz_out(div_zero)
  );

  // R7: one-cycle result strobe
  p_done_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R5: published results are normalized decimal digits
  p_norm_r5: assert property (@(posedge clk) disable iff (rst)
    (done && !div_zero) |-> (quotient[MW-1 -: 4] != 4'd0 && quotient[MW-1 -: 4] <= 4'd9));

  // R6: divide-by-zero result is cleared
  p_dz_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (done && div_zero) |-> (quotient == '0));

  // R9: outputs hold between strobes
  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(div_zero)));
endmodule

// File: tb/bcdfp_div_test.sv
module bcdfp_div_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  typedef struct {
    logic [31:0] q;
    logic        dz;
    string       mtag;
    string       etag;
  } item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] dividend = '0, divisor = '0;
  logic [31:0] quotient;
  logic        done, div_zero;

  int checks = 0, failures = 0, cycles = 0;
  item_t sb[$];
  logic [31:0] last_q;

  bcdfp_div uut (
    .clk(clk), .rst(rst), .start(start), .dividend(dividend), .divisor(divisor),
    .quotient(quotient), .done(done), .div_zero(div_zero)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, WATCHDOG);
      finish_run();
    end
  end

  function automatic longint bcd6(input logic [23:0] m);
    longint v = 0;
    for (int i = 5; i >= 0; i--) v = v * 10 + m[4*i +: 4];
    return v;
  endfunction

  function automatic logic [23:0] to_bcd6(input longint v);
    logic [23:0] m;
    for (int i = 0; i < 6; i++) begin
      m[4*i +: 4] = 4'(v % 10);
      v = v / 10;
    end
    return m;
  endfunction

  function automatic int exp_val(input logic [6:0] c);
    int v = c[6:4] * 10 + c[3:0];
    return (v < 40) ? v : v - 80;
  endfunction

  task automatic pulse(input logic [31:0] a, input logic [31:0] b);
    @(negedge clk);
    dividend = a;
    divisor  = b;
    start    = 1'b1;
    @(negedge clk);
    start    = 1'b0;
  endtask

  // push the expected result, then launch
  task automatic do_div(input logic [31:0] a, input logic [31:0] b);
    item_t it;
    longint ma = bcd6(a[23:0]), mb = bcd6(b[23:0]), qm;
    int e, code;
    bit lead;
    if (mb == 0) begin
      it.q = '0; it.dz = 1'b1; it.mtag = "R6"; it.etag = "R6";
    end else begin
      lead = (ma < mb);
      qm   = lead ? (ma * 1000000) / mb : (ma * 100000) / mb;
      e    = exp_val(a[30:24]) - exp_val(b[30:24]) - int'(lead);
      code = ((e % 80) + 80) % 80;
      it.q = {a[31] ^ b[31], 3'(code / 10), 4'(code % 10), to_bcd6(qm)};
      it.dz = 1'b0;
      it.mtag = lead ? "R5" : "R2";
      it.etag = lead ? "R5" : "R4";
    end
    sb.push_back(it);
    pulse(a, b);
    wait (sb.size() == 0);
  endtask

  // monitor: compares each strobe against the scoreboard head
  initial begin
    item_t it;
    forever begin
      @(negedge clk);
      if (!rst && done) begin
        if (sb.size() == 0) begin
          chk(1'b0, "R8 unexpected done", 1, 0);
        end else begin
          it = sb.pop_front();
          chk(quotient[23:0] == it.q[23:0], {it.mtag, " mantissa"}, quotient[23:0], it.q[23:0]);
          chk(quotient[30:24] == it.q[30:24], {it.etag, " exponent"}, quotient[30:24], it.q[30:24]);
          chk(quotient[31] == it.q[31], "R3 sign", quotient[31], it.q[31]);
          chk(div_zero == it.dz, it.dz ? "R6 div_zero" : "R7 div_zero", div_zero, it.dz);
          last_q = quotient;
        end
        @(negedge clk);
        chk(!done, "R7 done pulse width", done, 0);
      end
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    chk(quotient == 0, "R1 quotient reset", quotient, 0);
    chk(done == 0, "R1 done reset", done, 0);
    chk(div_zero == 0, "R1 div_zero reset", div_zero, 0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    do_div({1'b0, 7'h00, 24'h600000}, {1'b0, 7'h00, 24'h300000}); // R2 6/3
    do_div({1'b0, 7'h00, 24'h200000}, {1'b0, 7'h00, 24'h300000}); // R5 2/3
    do_div({1'b0, 7'h03, 24'h999999}, {1'b0, 7'h01, 24'h100000}); // R2 digit 9
    do_div({1'b0, 7'h00, 24'h100000}, {1'b0, 7'h00, 24'h999999}); // R5
    do_div({1'b0, 7'h05, 24'h123456}, {1'b1, 7'h78, 24'h314159}); // R3 R4 R5
    do_div({1'b1, 7'h12, 24'h777777}, {1'b1, 7'h02, 24'h111111}); // R3 R2
    do_div({1'b0, 7'h39, 24'h500000}, {1'b0, 7'h40, 24'h250000}); // R4 wrap
    do_div({1'b0, 7'h00, 24'h100000}, {1'b0, 7'h00, 24'h100001}); // R5 truncation
    do_div({1'b1, 7'h21, 24'h314159}, {1'b0, 7'h21, 24'h314159}); // R2 equal
    do_div({1'b0, 7'h00, 24'h987654}, {1'b0, 7'h00, 24'h123457}); // R2

    // R9: result held while idle
    repeat (20) @(negedge clk);
    chk(quotient == last_q, "R9 hold", quotient, last_q);

    // R6: zero divisor, strobe right after start
    do_div({1'b0, 7'h04, 24'h250000}, {1'b1, 7'h07, 24'h000000});
    repeat (10) @(negedge clk);
    chk(div_zero == 1'b1, "R9 div_zero hold", div_zero, 1);

    // R8: start while busy is ignored
    begin
      item_t it;
      logic [31:0] a = {1'b0, 7'h01, 24'h400000};
      logic [31:0] b = {1'b0, 7'h00, 24'h700000};
      it.q = {1'b0, 7'h00, 24'h571428}; it.dz = 1'b0; it.mtag = "R5"; it.etag = "R5";
      sb.push_back(it);
      pulse(a, b);
      repeat (3) @(negedge clk);
      pulse({1'b1, 7'h10, 24'h900000}, {1'b0, 7'h00, 24'h000000});
      wait (sb.size() == 0);
      repeat (200) @(negedge clk);
      chk(quotient == it.q, "R8 result after busy start", quotient, it.q);
    end

    repeat (5) @(negedge clk);
    finish_run();
  end
endmodule